// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Status Registers

This block keeps the pending-interrupt state of a two-channel disk controller and folds it into one interrupt line. Each channel's pending flag is stored twice. One copy sits in a per-channel legacy status byte. The other sits in a shared mode byte, which also holds a per-channel block (mask) bit. Both copies live in a byte-addressed configuration space.

A configuration write that clears either copy of a flag also clears the other copy. A change on a channel's level input updates both copies together. The output line is high when either channel has a pending flag that its block bit does not hide.

Software clears flags by writing ones through configuration space. The block bits cannot be written there. They are loaded through a separate side port that only touches those two bits. Reads through configuration space are combinational from the stored state.

Top module: `irq_mirror_regs`

## Requirements
- R1: After synchronous reset, every pending flag and block bit is zero, `irq_out` is low, and bytes 0x50, 0x57 and 0x71 read as 0x00.
- R2: A channel level input sampled high at a clock edge sets that channel's pending flag at that edge. A level sampled low clears the flag. Both copies change together: channel 0 appears in bit 2 of 0x50 and bit 2 of 0x71, and channel 1 appears in bit 4 of 0x57 and bit 3 of 0x71.
- R3: A configuration write to 0x50 with bit 2 set clears channel 0 in both copies. With bit 2 clear, the write changes nothing.
- R4: A configuration write to 0x57 with bit 4 set clears channel 1 in both copies. With bit 4 clear, the write changes nothing.
- R5: A configuration write to 0x71 clears channel 0 in both copies when bit 2 of the data is set, and clears channel 1 in both copies when bit 3 is set.
- R6: Configuration writes never change the block bits (bit 4 of 0x71 for channel 0, bit 5 for channel 1). No other non-pending bit of 0x50, 0x57 or 0x71 can be set by them.
- R7: `irq_out` is high exactly when some channel has its pending flag set and its block bit clear.
- R8: A side-port write loads bits 4 and 5 of `side_wdata` into the two block bits at the clock edge and leaves the pending flags unchanged. `irq_out` reflects the new block bits right after that edge.
- R9: If a flag is cleared while its channel level is still high, the flag is set again at the next clock edge.
- R10: Byte 0x51 reads with bit 2 set, and with bit 3 set only when `SECONDARY_EN` is 1. Every other bit of 0x51 reads 0, and configuration writes do not change it.
- R11: Configuration writes to any other address have no effect, and reads from any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_lvl | input | 2 | Interrupt levels from the channel cores, bit i is channel i |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address (write and read) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr`, combinational |
| side_wr_en | input | 1 | Side-port write strobe for the block bits |
| side_wdata | input | 8 | Side-port data; only bits 4 and 5 are used |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench holds both levels high and sweeps every data byte through writes to each legacy byte, the mode byte and an unrelated address. After each write it reads all three copies.

A design that failed to mirror would show a cleared flag in one byte and a set flag in the other. A design with a wrong write mask would clear the other channel or let the block bits change. A design missing the re-set rule would leave a flag cleared while its input is still high.

Every side-port byte is swept to catch writes leaking into the pending flags. Every combination of levels and block bits is driven to check the gate on the output line. A design that swapped or inverted a block bit would raise the line while it is blocked.

// File: rtl/irqm_pkg.sv
// Shared constants and bit-position helpers for the mirrored interrupt
// register block. Assumes exactly two channels; positions are fixed because
// software decodes them.
package irqm_pkg;
    localparam int NUM_CH = 2;
    localparam int AW     = 8;
    localparam int DW     = 8;

    localparam logic [AW-1:0] ADDR_LEG0 = 8'h50;
    localparam logic [AW-1:0] ADDR_EN   = 8'h51;
    localparam logic [AW-1:0] ADDR_LEG1 = 8'h57;
    localparam logic [AW-1:0] ADDR_MODE = 8'h71;

    // Legacy status byte address of a channel
    function automatic logic [AW-1:0] leg_addr(input int ch);
        return (ch == 0) ? ADDR_LEG0 : ADDR_LEG1;
    endfunction

    // Pending bit position inside the legacy byte
    function automatic int leg_bit(input int ch);
        return (ch == 0) ? 2 : 4;
    endfunction

    // Pending bit position inside the shared mode byte
    function automatic int mode_bit(input int ch);
        return 2 + ch;
    endfunction

    // Block (mask) bit position inside the shared mode byte
    function automatic int mask_bit(input int ch);
        return 4 + ch;
    endfunction

    // Channel-enable bit position inside the enable byte
    function automatic int en_bit(input int ch);
        return 2 + ch;
    endfunction
endpackage

// File: rtl/irqm_edge_track.sv
// Remembers the previous sample of one channel level and classifies the
// current sample as rising, falling or steady high. Assumes the level is
// already synchronous to clk.
module irqm_edge_track (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall,
    output logic steady_hi
);
    logic lvl_prev;

    // Hold last sampled level; zero out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    // Classify the current sample against the previous one
    always_comb begin
        rise      = lvl & ~lvl_prev;
        fall      = ~lvl & lvl_prev;
        steady_hi = lvl & lvl_prev;
    end
endmodule

// File: rtl/irqm_chan_slice.sv
// One channel's pending flag, stored as a legacy copy and a mode-byte copy.
// A write-one-to-clear hit on either copy clears both (the other copy is
// recomputed from the written one). The level input then overrides: a rise
// sets, a fall clears, a steady high re-sets a flag not cleared this cycle.
module irqm_chan_slice
    import irqm_pkg::*;
#(
    parameter logic [AW-1:0] LEG_ADDR = ADDR_LEG0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          wd_leg_bit,
    input  logic          wd_mode_bit,
    output logic          leg_q,
    output logic          mode_q
);
    logic rise, fall, steady_hi;
    logic w1c_leg, w1c_mode;
    logic leg_a, mode_a, pend_b, pend_c;

    irqm_edge_track u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .rise      (rise),
        .fall      (fall),
        .steady_hi (steady_hi)
    );

    // Decode clear hits on each copy
    always_comb begin
        w1c_leg  = wr_en && (addr == LEG_ADDR)  && wd_leg_bit;
        w1c_mode = wr_en && (addr == ADDR_MODE) && wd_mode_bit;
    end

    // Apply clears per copy, mirror, then let the level input decide
    always_comb begin
        leg_a  = w1c_leg  ? 1'b0 : leg_q;
        mode_a = w1c_mode ? 1'b0 : mode_q;
        pend_b = leg_a & mode_a;
        if (rise)                                  pend_c = 1'b1;
        else if (fall)                             pend_c = 1'b0;
        else if (steady_hi && !(w1c_leg || w1c_mode)) pend_c = 1'b1;
        else                                       pend_c = pend_b;
    end

    // Store both copies of the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            leg_q  <= pend_c;
            mode_q <= pend_c;
        end
    end
endmodule

// File: rtl/irqm_mask_reg.sv
// Block bits for all channels, loaded only from the side port. Assumes the
// caller has already picked the block-bit positions out of the side byte.
module irqm_mask_reg
    import irqm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] mask_q
);
    // Load block bits on a side write; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wbits;
    end
endmodule

// File: rtl/irqm_read_mux.sv
// Combinational configuration readback. Unmapped addresses and unused bit
// positions return zero.
module irqm_read_mux
    import irqm_pkg::*;
#(
    parameter logic [DW-1:0] EN_VALUE = 8'h04
) (
    input  logic [AW-1:0]     addr,
    input  logic [NUM_CH-1:0] leg,
    input  logic [NUM_CH-1:0] mode,
    input  logic [NUM_CH-1:0] mask,
    output logic [DW-1:0]     rdata
);
    // Assemble the addressed byte from stored bits
    always_comb begin
        rdata = '0;
        if (addr == ADDR_EN) rdata = EN_VALUE;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr == leg_addr(ch)) rdata[leg_bit(ch)] = leg[ch];
            if (addr == ADDR_MODE) begin
                rdata[mode_bit(ch)] = mode[ch];
                rdata[mask_bit(ch)] = mask[ch];
            end
        end
    end
endmodule

// File: rtl/irq_mirror_regs.sv
// Top of the mirrored interrupt status block: two channel slices, the
// block-bit register, the readback mux and the output gate. Assumes the
// channel levels and all strobes are synchronous to clk.
module irq_mirror_regs
    import irqm_pkg::*;
#(
    parameter bit SECONDARY_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_lvl,
    input  logic              cfg_wr_en,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              side_wr_en,
    input  logic [DW-1:0]     side_wdata,
    output logic              irq_out
);
    localparam logic [DW-1:0] EN_VALUE =
        (DW'(1) << en_bit(0)) | (SECONDARY_EN ? (DW'(1) << en_bit(1)) : DW'(0));

    logic [NUM_CH-1:0] leg_pend;
    logic [NUM_CH-1:0] mode_pend;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] side_bits;
    logic              unused_data;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            irqm_chan_slice #(
                .LEG_ADDR (leg_addr(i))
            ) u_slice (
                .clk         (clk),
                .rst_n       (rst_n),
                .lvl         (chan_lvl[i]),
                .wr_en       (cfg_wr_en),
                .addr        (cfg_addr),
                .wd_leg_bit  (cfg_wdata[leg_bit(i)]),
                .wd_mode_bit (cfg_wdata[mode_bit(i)]),
                .leg_q       (leg_pend[i]),
                .mode_q      (mode_pend[i])
            );
            assign side_bits[i] = side_wdata[mask_bit(i)];
        end
    endgenerate

    irqm_mask_reg u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (side_wr_en),
        .wbits  (side_bits),
        .mask_q (mask_q)
    );

    irqm_read_mux #(
        .EN_VALUE (EN_VALUE)
    ) u_rd (
        .addr  (cfg_addr),
        .leg   (leg_pend),
        .mode  (mode_pend),
        .mask  (mask_q),
        .rdata (cfg_rdata)
    );

    // Gate pending flags with block bits into the single line
    always_comb begin
        irq_out = |(mode_pend & ~mask_q);
    end

    // Bits of the data bytes that no register takes
    assign unused_data = ^{cfg_wdata[7:5], cfg_wdata[1:0],
                           side_wdata[7:6], side_wdata[3:0]};
endmodule

// File: rtl/irqm_checker.sv
// Property checker for irq_mirror_regs, attached by bind. Watches the ports
// and the stored flag copies and block bits.
module irqm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] chan_lvl,
    input logic       cfg_wr_en,
    input logic       side_wr_en,
    input logic [7:0] side_wdata,
    input logic       irq_out,
    input logic [1:0] leg_pend,
    input logic [1:0] mode_pend,
    input logic [1:0] mask_q
);
    // R2: the two stored copies never disagree
    a_r2_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
        leg_pend == mode_pend);

    // R2: a low level clears the channel at the edge
    a_r2_low_clears_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_lvl[0] |=> !mode_pend[0]);
    a_r2_low_clears_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_lvl[1] |=> !mode_pend[1]);

    // R9: a cleared flag with its level still high comes back
    a_r9_refill_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_lvl[0] && !mode_pend[0] && !cfg_wr_en) |=> mode_pend[0]);
    a_r9_refill_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_lvl[1] && !mode_pend[1] && !cfg_wr_en) |=> mode_pend[1]);

    // R8: side write loads both block bits
    a_r8_side_load: assert property (@(posedge clk) disable iff (!rst_n)
        side_wr_en |=> (mask_q == {$past(side_wdata[5]), $past(side_wdata[4])}));

    // R6: block bits hold without a side write
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !side_wr_en |=> $stable(mask_q));

    // R7: fully blocked means a quiet line
    a_r7_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b11) |-> !irq_out);
endmodule

bind irq_mirror_regs irqm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_lvl   (chan_lvl),
    .cfg_wr_en  (cfg_wr_en),
    .side_wr_en (side_wr_en),
    .side_wdata (side_wdata),
    .irq_out    (irq_out),
    .leg_pend   (leg_pend),
    .mode_pend  (mode_pend),
    .mask_q     (mask_q)
);

// File: tb/irq_mirror_regs_bench.sv
`timescale 1ns/1ps
module irq_mirror_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chan_lvl = 2'b00;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata, rdata_sec;
    logic       side_wr_en = 1'b0;
    logic [7:0] side_wdata = 8'h00;
    logic       irq_out, irq_sec;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_mirror_regs u_irq_mirror_regs (
        .clk(clk), .rst_n(rst_n), .chan_lvl(chan_lvl),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .side_wr_en(side_wr_en),
        .side_wdata(side_wdata), .irq_out(irq_out)
    );

    irq_mirror_regs #(.SECONDARY_EN(1'b1)) u_sec (
        .clk(clk), .rst_n(rst_n), .chan_lvl(chan_lvl),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_sec), .side_wr_en(side_wr_en),
        .side_wdata(side_wdata), .irq_out(irq_sec)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        cfg_addr = a;
        #0.2;
        v = cfg_rdata;
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        cycle();
        cfg_wr_en = 1'b0;
    endtask

    task automatic side_write(input logic [7:0] d);
        side_wr_en = 1'b1; side_wdata = d;
        cycle();
        side_wr_en = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] addrs [4];
        addrs[0] = 8'h50; addrs[1] = 8'h57; addrs[2] = 8'h71; addrs[3] = 8'h52;

        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();

        // R1: reset state
        rd(8'h71, v); check("R1 mode byte", v, 8'h00);
        rd(8'h50, v); check("R1 legacy ch0", v, 8'h00);
        rd(8'h57, v); check("R1 legacy ch1", v, 8'h00);
        check("R1 irq", irq_out, 0);

        // R10: enable byte in both variants, write ignored
        cfg_write(8'h51, 8'hFF);
        rd(8'h51, v); check("R10 enable primary", v, 8'h04);
        check("R10 enable secondary", rdata_sec, 8'h0C);

        // R2: rise sets both copies at the edge, not before
        chan_lvl = 2'b01;
        rd(8'h71, v); check("R2 before edge", v, 8'h00);
        cycle();
        rd(8'h71, v); check("R2 mode ch0 set", v, 8'h04);
        rd(8'h50, v); check("R2 legacy ch0 set", v, 8'h04);
        chan_lvl = 2'b10;
        cycle();
        rd(8'h71, v); check("R2 ch0 falls ch1 rises", v, 8'h08);
        rd(8'h57, v); check("R2 legacy ch1 set", v, 8'h10);
        rd(8'h50, v); check("R2 legacy ch0 clear", v, 8'h00);

        // R3 R4 R5 R6 R9 R11: all data bytes to each address, levels high
        chan_lvl = 2'b11;
        cycle();
        foreach (addrs[ai]) begin
            for (int d = 0; d < 256; d++) begin
                logic [7:0] a;
                logic [7:0] dd;
                logic e0, e1;
                string tag;
                a = addrs[ai];
                dd = 8'(d);
                e0 = !(((a == 8'h50) && dd[2]) || ((a == 8'h71) && dd[2]));
                e1 = !(((a == 8'h57) && dd[4]) || ((a == 8'h71) && dd[3]));
                tag = (a == 8'h50) ? "R3" : (a == 8'h57) ? "R4" :
                      (a == 8'h71) ? "R5" : "R11";
                cfg_write(a, dd);
                rd(8'h71, v);
                check({tag, " mode pend"}, int'(v[3:2]), int'({e1, e0}));
                check("R6 block bits and spare bits", int'({v[7:4], v[1:0]}), 0);
                rd(8'h50, v); check({tag, " legacy ch0"}, v, {5'b0, e0, 2'b0});
                rd(8'h57, v); check({tag, " legacy ch1"}, v, {3'b0, e1, 4'b0});
                if (a == 8'h52) begin
                    rd(8'h52, v); check("R11 unmapped read", v, 8'h00);
                end
                cycle();
                rd(8'h71, v); check("R9 re-set while high", v, 8'h0C);
            end
        end

        // R8: every side byte, levels high
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dd;
            dd = 8'(d);
            side_write(dd);
            rd(8'h71, v);
            check("R8 side load", v, (dd & 8'h30) | 8'h0C);
            check("R8 irq after side", irq_out, int'(!(dd[4] && dd[5])));
        end

        // R7: every level and block combination
        for (int lv = 0; lv < 4; lv++) begin
            for (int m = 0; m < 4; m++) begin
                logic [1:0] l2, m2;
                l2 = 2'(lv); m2 = 2'(m);
                chan_lvl = l2;
                side_write({2'b0, m2, 4'b0});
                check("R7 irq gate", irq_out, int'(|(l2 & ~m2)));
                rd(8'h71, v);
                check("R2 pend follows level", int'(v[3:2]), int'(l2));
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule